// File: doc/BRIEF.md
# MMU and Exception Control Register Bank

This block is a bank of processor control registers that sits on a 32-bit register bus. It stores address translation controls: the MMU control word, the high and low halves of a page-table entry, a page-table assistance field and the translation table base. It also holds the exception and trap state: the faulting address, the trap code, the exception event code and the interrupt event code. Alongside these it keeps a refresh counter that advances on every read, three read-only identification constants, and a group of wait and memory control slots. Those slots accept writes and read back as zero.

Some writes act on the translation buffer, which lives outside this block. A write that sets the invalidate bit of the MMU control word raises `tlb_inval_pulse`. A write to the page-table-entry-high register that changes its address-space identifier raises `tlb_flush_pulse`. Each pulse lasts one cycle and coincides with the first cycle of the matching response.

Requests arrive on a valid/ready channel. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. Each taken request produces exactly one response, one cycle later, on a second valid/ready channel. While `rsp_valid` is high and `rsp_ready` is low, the response data and error flag are held unchanged. The access size is given by the byte enables: `4'b1111` is a word access and `4'b0011` is a half-word access. Any other pattern is an error.

Top module: `mmu_ctl_regbank`

## Requirements
- R1: After reset, every stored register reads zero, the refresh counter is zero, both pulse outputs are low, `rsp_valid` is low and `req_ready` is high.
- R2: A word write to the MMU control word (offset 0x00) stores the data with bit 2 forced to zero. If bit 2 of the write data is set, `tlb_inval_pulse` is high in the first cycle of that write's response, and low otherwise.
- R3: A word write to page-table-entry-high (offset 0x04) stores all 32 bits. `tlb_flush_pulse` is high in the first cycle of its response only when the new bits 7:0 differ from the stored bits 7:0.
- R4: The page-table assistance register (0x20) keeps only bits 3:0. Page-table-entry-low (0x08), table base (0x0C) and fault address (0x10) keep all 32 bits.
- R5: The trap code (0x14), exception event (0x18) and interrupt event (0x1C) registers keep only bits 10:0, and read zero above bit 10.
- R6: The refresh counter (0x24) is 16 bits wide and takes half-word accesses only (byte enables `4'b0011`, data on bits 15:0). A read returns the current value and then adds one, wrapping from 0xFFFF to 0. A write loads the counter.
- R7: Identification constants read back at 0x30 (processor version), 0x40 (cache version) and 0x44 (processor revision). A write to any of them is an error.
- R8: The wait and memory control slots at 0x50, 0x54, 0x58 and 0x5C take word writes without error and without effect, and read as zero.
- R9: A single-byte enable, an enable pattern that does not match the register's width, a misaligned offset or an unmapped offset gives a response with `rsp_err` high and `rsp_rdata` zero. Such an access changes no register, does not advance the refresh counter and raises no pulse.
- R10: Responses come back in request order, one cycle after acceptance. A stalled response holds its data and error flag stable, and `req_ready` stays low while `rsp_valid` is high and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_be | input | 4 | Byte enables, giving the access size |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Access was rejected |
| tlb_inval_pulse | output | 1 | One-cycle request to invalidate the whole translation buffer |
| tlb_flush_pulse | output | 1 | One-cycle request to flush translations after an address-space change |

## Verification
Page-table-entry-high is written three times: twice with the same address-space identifier but different upper bits, and then once with a new identifier. Only the last write should raise a flush, which separates a comparison of the low byte from a comparison of the whole word. The MMU control word is written once with bit 2 set and once with it clear, so the bench can tell the pulse source apart from the stored value. The refresh counter is read in sequence, loaded with 0xFFFF and read across the wrap, and it is also hit by a rejected access to show that errors do not advance it. A final run with `rsp_ready` held low in two cycles out of three mixes reads, writes, a flush and an error. This shows that stalled responses are neither dropped nor repeated.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_MMU,
    SEL_PTEHI,
    SEL_PTELO,
    SEL_TBASE,
    SEL_FADDR,
    SEL_AUX,
    SEL_TRAP,
    SEL_EXCEV,
    SEL_INTEV,
    SEL_RFCNT,
    SEL_PVER,
    SEL_CVER,
    SEL_PREV,
    SEL_NULL
  } mrb_sel_e;

  localparam int N_WIDE = 3;
  localparam int N_EVT  = 3;
  localparam int N_NULL = 4;

  localparam logic [7:0] OFF_MMU   = 8'h00;
  localparam logic [7:0] OFF_PTEHI = 8'h04;
  localparam logic [7:0] OFF_PTELO = 8'h08;
  localparam logic [7:0] OFF_TBASE = 8'h0C;
  localparam logic [7:0] OFF_FADDR = 8'h10;
  localparam logic [7:0] OFF_TRAP  = 8'h14;
  localparam logic [7:0] OFF_EXCEV = 8'h18;
  localparam logic [7:0] OFF_INTEV = 8'h1C;
  localparam logic [7:0] OFF_AUX   = 8'h20;
  localparam logic [7:0] OFF_RFCNT = 8'h24;
  localparam logic [7:0] OFF_PVER  = 8'h30;
  localparam logic [7:0] OFF_CVER  = 8'h40;
  localparam logic [7:0] OFF_PREV  = 8'h44;
  localparam logic [7:0] OFF_NULL0 = 8'h50;

  localparam logic [3:0] BE_WORD = 4'b1111;
  localparam logic [3:0] BE_HALF = 4'b0011;

  function automatic mrb_sel_e wide_sel(input int i);
    case (i)
      0:       return SEL_PTELO;
      1:       return SEL_TBASE;
      default: return SEL_FADDR;
    endcase
  endfunction

  function automatic mrb_sel_e evt_sel(input int i);
    case (i)
      0:       return SEL_TRAP;
      1:       return SEL_EXCEV;
      default: return SEL_INTEV;
    endcase
  endfunction

endpackage

// File: rtl/mrb_decode.sv
module mrb_decode
  import mrb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic              write,
  output mrb_sel_e          sel,
  output logic              err
);

  logic size_ok;
  logic ro_hit;
  logic null_hit;

  always_comb begin
    null_hit = 1'b0;
    for (int k = 0; k < N_NULL; k++) begin
      if (addr == ADDR_W'(OFF_NULL0 + 8'(4 * k))) null_hit = 1'b1;
    end
  end

  always_comb begin
    sel = SEL_NONE;
    if (null_hit) sel = SEL_NULL;
    else begin
      case (addr)
        ADDR_W'(OFF_MMU):   sel = SEL_MMU;
        ADDR_W'(OFF_PTEHI): sel = SEL_PTEHI;
        ADDR_W'(OFF_PTELO): sel = SEL_PTELO;
        ADDR_W'(OFF_TBASE): sel = SEL_TBASE;
        ADDR_W'(OFF_FADDR): sel = SEL_FADDR;
        ADDR_W'(OFF_TRAP):  sel = SEL_TRAP;
        ADDR_W'(OFF_EXCEV): sel = SEL_EXCEV;
        ADDR_W'(OFF_INTEV): sel = SEL_INTEV;
        ADDR_W'(OFF_AUX):   sel = SEL_AUX;
        ADDR_W'(OFF_RFCNT): sel = SEL_RFCNT;
        ADDR_W'(OFF_PVER):  sel = SEL_PVER;
        ADDR_W'(OFF_CVER):  sel = SEL_CVER;
        ADDR_W'(OFF_PREV):  sel = SEL_PREV;
        default:            sel = SEL_NONE;
      endcase
    end
  end

  assign size_ok = (sel == SEL_RFCNT) ? (be == BE_HALF) : (be == BE_WORD);
  assign ro_hit  = write && (sel == SEL_PVER || sel == SEL_CVER || sel == SEL_PREV);
  assign err     = (sel == SEL_NONE) || !size_ok || ro_hit;

  // single-byte access must always be rejected
  always_comb begin
    if (!$isunknown(be) && $countones(be) == 1) begin
      assert_byte_err_R9: assert (err);
    end
  end

endmodule

// File: rtl/mrb_store.sv
module mrb_store
  import mrb_pkg::*;
#(
  parameter int          INVAL_BIT = 2,
  parameter int          ASID_W    = 8,
  parameter int          AUX_W     = 4,
  parameter int          EVT_W     = 11,
  parameter int          RF_W      = 16,
  parameter logic [31:0] PVER_VAL  = 32'h0405_0300,
  parameter logic [31:0] CVER_VAL  = 32'h0000_2020,
  parameter logic [31:0] PREV_VAL  = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        wr,
  input  mrb_sel_e    sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        inval_pulse,
  output logic        flush_pulse
);

  localparam logic [31:0] INVAL_MASK = ~(32'd1 << INVAL_BIT);

  logic [31:0]      mmu_q;
  logic [31:0]      ptehi_q;
  logic [31:0]      wide_q [N_WIDE];
  logic [EVT_W-1:0] evt_q  [N_EVT];
  logic [AUX_W-1:0] aux_q;
  logic [RF_W-1:0]  rfcnt_q;
  logic             inval_q, flush_q;

  logic wr_en, rd_en;
  assign wr_en = acc && wr;
  assign rd_en = acc && !wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmu_q   <= '0;
      ptehi_q <= '0;
      aux_q   <= '0;
      inval_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      inval_q <= wr_en && (sel == SEL_MMU) && wdata[INVAL_BIT];
      flush_q <= wr_en && (sel == SEL_PTEHI) &&
                 (wdata[ASID_W-1:0] != ptehi_q[ASID_W-1:0]);
      if (wr_en && sel == SEL_MMU)   mmu_q   <= wdata & INVAL_MASK;
      if (wr_en && sel == SEL_PTEHI) ptehi_q <= wdata;
      if (wr_en && sel == SEL_AUX)   aux_q   <= wdata[AUX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WIDE; i++) wide_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_WIDE; i++)
        if (wr_en && sel == wide_sel(i)) wide_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_EVT; i++) evt_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_EVT; i++)
        if (wr_en && sel == evt_sel(i)) evt_q[i] <= wdata[EVT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          rfcnt_q <= '0;
    else if (wr_en && sel == SEL_RFCNT)  rfcnt_q <= wdata[RF_W-1:0];
    else if (rd_en && sel == SEL_RFCNT)  rfcnt_q <= rfcnt_q + 1'b1;
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_MMU:   rdata = mmu_q;
      SEL_PTEHI: rdata = ptehi_q;
      SEL_PTELO: rdata = wide_q[0];
      SEL_TBASE: rdata = wide_q[1];
      SEL_FADDR: rdata = wide_q[2];
      SEL_TRAP:  rdata = 32'(evt_q[0]);
      SEL_EXCEV: rdata = 32'(evt_q[1]);
      SEL_INTEV: rdata = 32'(evt_q[2]);
      SEL_AUX:   rdata = 32'(aux_q);
      SEL_RFCNT: rdata = 32'(rfcnt_q);
      SEL_PVER:  rdata = PVER_VAL;
      SEL_CVER:  rdata = CVER_VAL;
      SEL_PREV:  rdata = PREV_VAL;
      default:   rdata = '0;
    endcase
  end

  assign inval_pulse = inval_q;
  assign flush_pulse = flush_q;

  assert_rfcnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_RFCNT) |=> rfcnt_q == $past(rfcnt_q) + 1'b1);

  assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(mmu_q) && $stable(ptehi_q) && $stable(aux_q) &&
              $stable(rfcnt_q) && !inval_q && !flush_q));

  assert_mmu_bit_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_MMU) |=> !mmu_q[INVAL_BIT]);

endmodule

// File: rtl/mrb_resp.sv
module mrb_resp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] ld_data,
  input  logic        ld_err,
  input  logic        rsp_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        can_take
);

  assign can_take = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= ld_data;
      rsp_err   <= ld_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == '0);

endmodule

// File: rtl/mmu_ctl_regbank.sv
module mmu_ctl_regbank
  import mrb_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          INVAL_BIT = 2,
  parameter int          ASID_W    = 8,
  parameter int          AUX_W     = 4,
  parameter int          EVT_W     = 11,
  parameter int          RF_W      = 16,
  parameter logic [31:0] PVER_VAL  = 32'h0405_0300,
  parameter logic [31:0] CVER_VAL  = 32'h0000_2020,
  parameter logic [31:0] PREV_VAL  = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              tlb_inval_pulse,
  output logic              tlb_flush_pulse
);

  mrb_sel_e    dec_sel;
  logic        dec_err;
  logic        fire, acc;
  logic [31:0] st_rdata;
  logic [31:0] ld_data;

  mrb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (req_addr),
    .be    (req_be),
    .write (req_write),
    .sel   (dec_sel),
    .err   (dec_err)
  );

  assign fire = req_valid && req_ready;
  assign acc  = fire && !dec_err;

  mrb_store #(
    .INVAL_BIT (INVAL_BIT),
    .ASID_W    (ASID_W),
    .AUX_W     (AUX_W),
    .EVT_W     (EVT_W),
    .RF_W      (RF_W),
    .PVER_VAL  (PVER_VAL),
    .CVER_VAL  (CVER_VAL),
    .PREV_VAL  (PREV_VAL)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .wr          (req_write),
    .sel         (dec_sel),
    .wdata       (req_wdata),
    .rdata       (st_rdata),
    .inval_pulse (tlb_inval_pulse),
    .flush_pulse (tlb_flush_pulse)
  );

  assign ld_data = (req_write || dec_err) ? 32'd0 : st_rdata;

  mrb_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .ld_data   (ld_data),
    .ld_err    (dec_err),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .can_take  (req_ready)
  );

  assert_inval_with_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inval_pulse |-> (rsp_valid && !rsp_err));

  assert_flush_with_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_pulse |-> (rsp_valid && !rsp_err));

  assert_stall_blocks_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

// File: tb/mmu_ctl_regbank_test.sv
module mmu_ctl_regbank_test;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] T_PVER = 32'h0A0B_0C01;
  localparam logic [31:0] T_CVER = 32'h1122_3344;
  localparam logic [31:0] T_PREV = 32'h0000_00A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        tlb_inval_pulse, tlb_flush_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_ctl_regbank #(
    .PVER_VAL (T_PVER),
    .CVER_VAL (T_CVER),
    .PREV_VAL (T_PREV)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_be (req_be), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_rdata (rsp_rdata),
    .rsp_err (rsp_err), .tlb_inval_pulse (tlb_inval_pulse),
    .tlb_flush_pulse (tlb_flush_pulse)
  );

  typedef struct {
    logic [31:0] d;
    bit          e;
    bit          i;
    bit          f;
    int          rq;
  } exp_t;

  exp_t sbq[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   bp_on = 1'b0;
  int   bp_cnt = 0;
  bit   seen_inv = 1'b0;
  bit   seen_fl = 1'b0;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // response back-pressure driver
  initial begin
    forever begin
      @(posedge clk); #1;
      if (bp_on) begin
        rsp_ready = (bp_cnt % 3 == 2);
        bp_cnt++;
      end else rsp_ready = 1'b1;
    end
  end

  // monitor: pops and compares
  initial begin
    forever begin
      @(negedge clk);
      if (tlb_inval_pulse) seen_inv = 1'b1;
      if (tlb_flush_pulse) seen_fl = 1'b1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R10 unexpected response", {32'd0, rsp_rdata}, 64'd0);
        end else begin
          exp_t x;
          x = sbq.pop_front();
          n_checks++;
          if (rsp_rdata !== x.d || rsp_err !== x.e || seen_inv != x.i || seen_fl != x.f) begin
            n_fail++;
            $display("FAIL R%0d actual d=%h e=%0b inv=%0b fl=%0b expected d=%h e=%0b inv=%0b fl=%0b",
                     x.rq, rsp_rdata, rsp_err, seen_inv, seen_fl, x.d, x.e, x.i, x.f);
          end
        end
        seen_inv = 1'b0;
        seen_fl  = 1'b0;
      end
    end
  end

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [3:0] be,
                      input logic [31:0] wd, input logic [31:0] ed, input bit ee,
                      input bit ei, input bit ef, input int rq);
    exp_t x;
    @(negedge clk);
    req_write = wr; req_addr = a; req_be = be; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    x.d = ed; x.e = ee; x.i = ei; x.f = ef; x.rq = rq;
    sbq.push_back(x);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] ed, input int rq);
    xfer(1'b0, a, 4'hF, 32'd0, ed, 1'b0, 1'b0, 1'b0, rq);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd, input int rq);
    xfer(1'b1, a, 4'hF, wd, 32'd0, 1'b0, 1'b0, 1'b0, rq);
  endtask

  task automatic drain;
    int t = 0;
    while (sbq.size() != 0 && t < 200) begin
      @(negedge clk);
      t++;
    end
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(rsp_valid == 1'b0, "R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check(req_ready == 1'b1, "R1 req_ready", {63'd0, req_ready}, 64'd1);
    check(!tlb_inval_pulse && !tlb_flush_pulse, "R1 pulses",
          {62'd0, tlb_inval_pulse, tlb_flush_pulse}, 64'd0);
    rd(8'h00, 32'd0, 1);                                          // R1
    rd(8'h04, 32'd0, 1);                                          // R1
    rd(8'h14, 32'd0, 1);                                          // R1
    xfer(1'b0, 8'h24, 4'b0011, 0, 32'd0, 0, 0, 0, 1);             // R1 counter 0 -> 1

    // R2 invalidate bit
    xfer(1'b1, 8'h00, 4'hF, 32'hDEAD_BEEF, 0, 0, 1, 0, 2);
    rd(8'h00, 32'hDEAD_BEEB, 2);
    xfer(1'b1, 8'h00, 4'hF, 32'h0000_0010, 0, 0, 0, 0, 2);
    rd(8'h00, 32'h0000_0010, 2);

    // R3 flush only on address-space id change
    xfer(1'b1, 8'h04, 4'hF, 32'h1234_5600, 0, 0, 0, 0, 3);
    rd(8'h04, 32'h1234_5600, 3);
    xfer(1'b1, 8'h04, 4'hF, 32'hAAAA_AA00, 0, 0, 0, 0, 3);
    rd(8'h04, 32'hAAAA_AA00, 3);
    xfer(1'b1, 8'h04, 4'hF, 32'h0000_0077, 0, 0, 0, 1, 3);
    rd(8'h04, 32'h0000_0077, 3);

    // R4 widths
    wr(8'h20, 32'hFFFF_FFFF, 4); rd(8'h20, 32'h0000_000F, 4);
    wr(8'h08, 32'h89AB_CDEF, 4); rd(8'h08, 32'h89AB_CDEF, 4);
    wr(8'h0C, 32'h1357_9BDF, 4); rd(8'h0C, 32'h1357_9BDF, 4);
    wr(8'h10, 32'hF0E1_D2C3, 4); rd(8'h10, 32'hF0E1_D2C3, 4);

    // R5 eleven-bit event registers
    wr(8'h14, 32'hFFFF_FFFF, 5); rd(8'h14, 32'h0000_07FF, 5);
    wr(8'h18, 32'h1234_5678, 5); rd(8'h18, 32'h0000_0678, 5);
    wr(8'h1C, 32'hFFFF_F800, 5); rd(8'h1C, 32'h0000_0000, 5);

    // R9 rejected accesses leave state alone
    xfer(1'b0, 8'h00, 4'b0001, 0, 0, 1, 0, 0, 9);                 // byte read
    xfer(1'b1, 8'h00, 4'b0001, 32'h4, 0, 1, 0, 0, 9);             // byte write, bit 2 set
    rd(8'h00, 32'h0000_0010, 9);
    xfer(1'b1, 8'h14, 4'b0011, 32'h0, 0, 1, 0, 0, 9);             // width mismatch
    rd(8'h14, 32'h0000_07FF, 9);
    xfer(1'b1, 8'h04, 4'hF, 32'h0000_0099, 0, 0, 0, 1, 3);        // R3 new id
    xfer(1'b0, 8'h60, 4'hF, 0, 0, 1, 0, 0, 9);                    // unmapped
    xfer(1'b0, 8'h02, 4'b1100, 0, 0, 1, 0, 0, 9);                 // misaligned
    xfer(1'b0, 8'h24, 4'hF, 0, 0, 1, 0, 0, 9);                    // counter with word enables

    // R6 refresh counter
    xfer(1'b0, 8'h24, 4'b0011, 0, 32'd1, 0, 0, 0, 6);
    xfer(1'b0, 8'h24, 4'b0011, 0, 32'd2, 0, 0, 0, 6);
    xfer(1'b1, 8'h24, 4'b0011, 32'h0000_FFFF, 0, 0, 0, 0, 6);
    xfer(1'b0, 8'h24, 4'b0011, 0, 32'h0000_FFFF, 0, 0, 0, 6);
    xfer(1'b0, 8'h24, 4'b0011, 0, 32'h0000_0000, 0, 0, 0, 6);

    // R7 identification constants
    rd(8'h30, T_PVER, 7); rd(8'h40, T_CVER, 7); rd(8'h44, T_PREV, 7);
    xfer(1'b1, 8'h30, 4'hF, 32'h0, 0, 1, 0, 0, 7);
    rd(8'h30, T_PVER, 7);

    // R8 inert control slots
    wr(8'h50, 32'hFFFF_FFFF, 8); rd(8'h50, 32'd0, 8);
    wr(8'h5C, 32'h1234_5678, 8); rd(8'h5C, 32'd0, 8);
    rd(8'h58, 32'd0, 8);

    drain();

    // R10 under back-pressure
    bp_on = 1'b1;
    wr(8'h08, 32'h0BAD_F00D, 10);
    rd(8'h08, 32'h0BAD_F00D, 10);
    xfer(1'b1, 8'h04, 4'hF, 32'h0000_0078, 0, 0, 0, 1, 10);
    rd(8'h04, 32'h0000_0078, 10);
    rd(8'h30, T_PVER, 10);
    xfer(1'b0, 8'h61, 4'hF, 0, 0, 1, 0, 0, 10);
    xfer(1'b1, 8'h00, 4'hF, 32'h0000_0004, 0, 0, 1, 0, 10);
    rd(8'h00, 32'h0000_0000, 10);
    drain();
    bp_on = 1'b0;
    check(sbq.size() == 0, "R10 all responses returned", 64'(sbq.size()), 64'd0);

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule